// File: doc/BRIEF.md
# Masked Vector Lane Writeback Controller

This block wraps a packed 32-bit-per-lane arithmetic unit that performs a vector divide. It takes the instruction's encoding class, vector length, broadcast and memory-operand flags, masking controls and rounding fields. From these it produces the two operand vectors fed to the lanes and the rounding mode the lanes must use, combinationally in the same cycle. It then merges the lane results into a 512-bit destination, and that destination is registered and presented one cycle after the request.

The merge decides, lane by lane, whether a lane takes the lane result, keeps the old destination contents, or is cleared. It also handles bits above the active vector length. The older 128-bit form preserves those bits and reads its first operand from the destination itself. The newer forms clear them. The arithmetic itself lies outside the block.

Top module: `lane_writeback_unit`

## Requirements
- R1: The active lane count is 4 for the legacy class (code 0) and the 128-bit class (code 1), and 8 for the 256-bit class (code 2). For the masked class (code 3) it follows `vlen_code`: 0 gives 4 lanes, 1 gives 8 lanes, and 2 or 3 give 16 lanes. Each lane is 32 bits, and lane j occupies bits [32j+31:32j].
- R2: An active lane takes its lane result when writemasking is off, or when writemasking is on and its `opmask` bit is 1.
- R3: In the masked class with `use_mask`=1 and `zero_mask`=0, an active lane whose `opmask` bit is 0 keeps its `dest_old` value.
- R4: In the masked class with `use_mask`=1 and `zero_mask`=1, an active lane whose `opmask` bit is 0 becomes zero.
- R5: In the masked class with `bcast`=1 and `src2_is_mem`=1, every lane of `lane_opb` equals `src2[31:0]`. In all other cases lane j of `lane_opb` equals lane j of `src2`.
- R6: `round_mode` equals `embed_rc` only when the class is masked, `vlen_code` is 2, `bcast`=1 and `src2_is_mem`=0. Otherwise it equals `global_rc`. Both codes pass through as 2-bit values, unchanged.
- R7: For classes 1, 2 and 3, every destination bit above the active lane count is zero.
- R8: For the legacy class, destination bits [511:128] equal those of `dest_old`, and `lane_opa` equals `dest_old`. For the other classes, `lane_opa` equals `src1`.
- R9: For classes 0, 1 and 2, `opmask`, `use_mask` and `zero_mask` have no effect: every active lane is written.
- R10: `opmask` bits at or above the active lane count have no effect on the destination.
- R11: `out_valid` rises exactly one clock after an `in_valid` cycle and is low otherwise. `dest_new` holds that request's result. Reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe |
| enc_class | input | 2 | 0 legacy, 1 short 128-bit, 2 short 256-bit, 3 masked |
| vlen_code | input | 2 | Vector length for the masked class |
| bcast | input | 1 | Broadcast one element of the second source |
| src2_is_mem | input | 1 | Second source comes from memory |
| use_mask | input | 1 | Writemask in use (masked class only) |
| zero_mask | input | 1 | 1 zeroing, 0 merging |
| opmask | input | 16 | Per-lane write enables |
| embed_rc | input | 2 | Rounding code carried by the instruction |
| global_rc | input | 2 | Rounding code from the control register |
| dest_old | input | 512 | Prior destination register value |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector |
| lane_res | input | 512 | Results returned by the lanes |
| lane_opa | output | 512 | First operand to the lanes |
| lane_opb | output | 512 | Second operand to the lanes |
| round_mode | output | 2 | Selected rounding code |
| out_valid | output | 1 | Destination valid |
| dest_new | output | 512 | Final destination value |

## Verification
The bench aims at the lane-count boundaries. If a design miscounts lanes, lanes 4 or 8 take results that should be cleared, or lanes that should be written get cleared. It sets `opmask` bits above the active length, and a design that decodes the whole mask then leaks results into lanes that should read zero. It also runs the short classes with a zeroing mask armed, where a design that applies masks outside the masked class clears live lanes. The legacy form gets nonzero upper destination bits, which a design that clears uniformly would lose. The bench pairs broadcast with register sources at each length, which shows whether embedded rounding or broadcast is keyed to the wrong conditions.

// File: rtl/lwb_pkg.sv
`timescale 1ns/1ps
package lwb_pkg;
  localparam int LANE_W    = 32;
  localparam int MAX_LANES = 16;
  localparam int VEC_W     = LANE_W * MAX_LANES;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_SHORT128 = 2'd1,
    ENC_SHORT256 = 2'd2,
    ENC_MASKED = 2'd3
  } enc_class_e;
endpackage

// File: rtl/lwb_decode.sv
`timescale 1ns/1ps
// Instruction-level decode: active lanes, masking, broadcast, rounding source.
module lwb_decode #(
  parameter int LANE_W    = 32,
  parameter int MAX_LANES = 16
) (
  input  logic [1:0]           enc_class,
  input  logic [1:0]           vlen_code,
  input  logic                 bcast,
  input  logic                 src2_is_mem,
  input  logic                 use_mask,
  input  logic [1:0]           embed_rc,
  input  logic [1:0]           global_rc,
  output logic [MAX_LANES-1:0] lane_active,
  output logic                 keep_upper,
  output logic                 mask_en,
  output logic                 bcast_sel,
  output logic                 a_from_dest,
  output logic [1:0]           rm_sel
);
  import lwb_pkg::*;

  localparam int CNT_W  = $clog2(MAX_LANES + 1);
  localparam int N128   = (128 / LANE_W < MAX_LANES) ? 128 / LANE_W : MAX_LANES;
  localparam int N256   = (256 / LANE_W < MAX_LANES) ? 256 / LANE_W : MAX_LANES;
  localparam int N512   = (512 / LANE_W < MAX_LANES) ? 512 / LANE_W : MAX_LANES;

  enc_class_e       cls;
  logic [CNT_W-1:0] n_act;
  logic             is_masked;
  logic             full_len;

  assign cls       = enc_class_e'(enc_class);
  assign is_masked = (cls == ENC_MASKED);
  assign full_len  = (vlen_code == 2'd2);

  always_comb begin
    unique case (cls)
      ENC_LEGACY,
      ENC_SHORT128: n_act = CNT_W'(N128);
      ENC_SHORT256: n_act = CNT_W'(N256);
      default: begin
        unique case (vlen_code)
          2'd0:    n_act = CNT_W'(N128);
          2'd1:    n_act = CNT_W'(N256);
          default: n_act = CNT_W'(N512);
        endcase
      end
    endcase
  end

  // Thermometer of active lanes.
  for (genvar j = 0; j < MAX_LANES; j++) begin : g_act
    assign lane_active[j] = (CNT_W'(j) < n_act);
  end

  assign keep_upper  = (cls == ENC_LEGACY);
  assign a_from_dest = (cls == ENC_LEGACY);
  assign mask_en     = is_masked & use_mask;
  assign bcast_sel   = is_masked & bcast & src2_is_mem;

  always_comb begin
    if (is_masked && full_len && bcast && !src2_is_mem) begin
      rm_sel = embed_rc;
    end else begin
      rm_sel = global_rc;
    end
  end
endmodule

// File: rtl/lwb_operand_sel.sv
`timescale 1ns/1ps
// Builds the lane operand vectors, including single-element broadcast.
module lwb_operand_sel #(
  parameter int LANE_W    = 32,
  parameter int MAX_LANES = 16,
  localparam int VEC_W    = LANE_W * MAX_LANES
) (
  input  logic [VEC_W-1:0] dest_old,
  input  logic [VEC_W-1:0] src1,
  input  logic [VEC_W-1:0] src2,
  input  logic             a_from_dest,
  input  logic             bcast_sel,
  output logic [VEC_W-1:0] opa,
  output logic [VEC_W-1:0] opb
);
  logic [LANE_W-1:0] bc_elem;
  assign bc_elem = src2[LANE_W-1:0];

  assign opa = a_from_dest ? dest_old : src1;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_opb
    assign opb[j*LANE_W +: LANE_W] = bcast_sel ? bc_elem : src2[j*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lwb_lane_merge.sv
`timescale 1ns/1ps
// Per-lane destination merge: result, keep, or clear.
module lwb_lane_merge #(
  parameter int LANE_W    = 32,
  parameter int MAX_LANES = 16,
  localparam int VEC_W    = LANE_W * MAX_LANES
) (
  input  logic [MAX_LANES-1:0] lane_active,
  input  logic                 keep_upper,
  input  logic                 mask_en,
  input  logic                 zero_mask,
  input  logic [MAX_LANES-1:0] opmask,
  input  logic [VEC_W-1:0]     lane_res,
  input  logic [VEC_W-1:0]     dest_old,
  output logic [VEC_W-1:0]     dest_next
);
  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic              wr_en;
    logic [LANE_W-1:0] old_v;
    logic [LANE_W-1:0] res_v;
    logic [LANE_W-1:0] masked_v;
    logic [LANE_W-1:0] idle_v;

    assign old_v    = dest_old[j*LANE_W +: LANE_W];
    assign res_v    = lane_res[j*LANE_W +: LANE_W];
    assign wr_en    = !mask_en || opmask[j];
    assign masked_v = zero_mask ? '0 : old_v;
    assign idle_v   = keep_upper ? old_v : '0;

    assign dest_next[j*LANE_W +: LANE_W] =
      !lane_active[j] ? idle_v :
      wr_en           ? res_v  :
                        masked_v;
  end
endmodule

// File: rtl/lane_writeback_unit.sv
`timescale 1ns/1ps
// Top: operand steering, rounding select and registered destination writeback.
module lane_writeback_unit #(
  parameter int LANE_W    = 32,
  parameter int MAX_LANES = 16,
  localparam int VEC_W    = LANE_W * MAX_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           enc_class,
  input  logic [1:0]           vlen_code,
  input  logic                 bcast,
  input  logic                 src2_is_mem,
  input  logic                 use_mask,
  input  logic                 zero_mask,
  input  logic [MAX_LANES-1:0] opmask,
  input  logic [1:0]           embed_rc,
  input  logic [1:0]           global_rc,
  input  logic [VEC_W-1:0]     dest_old,
  input  logic [VEC_W-1:0]     src1,
  input  logic [VEC_W-1:0]     src2,
  input  logic [VEC_W-1:0]     lane_res,
  output logic [VEC_W-1:0]     lane_opa,
  output logic [VEC_W-1:0]     lane_opb,
  output logic [1:0]           round_mode,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     dest_new
);
  logic [MAX_LANES-1:0] lane_active;
  logic                 keep_upper;
  logic                 mask_en;
  logic                 bcast_sel;
  logic                 a_from_dest;
  logic [VEC_W-1:0]     dest_d;

  logic                 vld_q, vld_d;
  logic [VEC_W-1:0]     dest_q;
  logic                 dest_ce;

  lwb_decode #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_dec (
    .enc_class   (enc_class),
    .vlen_code   (vlen_code),
    .bcast       (bcast),
    .src2_is_mem (src2_is_mem),
    .use_mask    (use_mask),
    .embed_rc    (embed_rc),
    .global_rc   (global_rc),
    .lane_active (lane_active),
    .keep_upper  (keep_upper),
    .mask_en     (mask_en),
    .bcast_sel   (bcast_sel),
    .a_from_dest (a_from_dest),
    .rm_sel      (round_mode)
  );

  lwb_operand_sel #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_ops (
    .dest_old    (dest_old),
    .src1        (src1),
    .src2        (src2),
    .a_from_dest (a_from_dest),
    .bcast_sel   (bcast_sel),
    .opa         (lane_opa),
    .opb         (lane_opb)
  );

  lwb_lane_merge #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_merge (
    .lane_active (lane_active),
    .keep_upper  (keep_upper),
    .mask_en     (mask_en),
    .zero_mask   (zero_mask),
    .opmask      (opmask),
    .lane_res    (lane_res),
    .dest_old    (dest_old),
    .dest_next   (dest_d)
  );

  // Next-state
  always_comb begin
    vld_d   = in_valid;
    dest_ce = in_valid;
  end

  // Control register with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Datapath register, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (dest_ce) begin
      dest_q <= dest_d;
    end
  end

  assign out_valid = vld_q;
  assign dest_new  = dest_q;
endmodule

// File: rtl/lwb_checker.sv
`timescale 1ns/1ps
module lwb_checker #(
  parameter int VEC_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       enc_class,
  input logic [1:0]       vlen_code,
  input logic             bcast,
  input logic             src2_is_mem,
  input logic             use_mask,
  input logic             zero_mask,
  input logic [15:0]      opmask,
  input logic [1:0]       embed_rc,
  input logic [1:0]       global_rc,
  input logic [VEC_W-1:0] dest_old,
  input logic [VEC_W-1:0] src1,
  input logic [VEC_W-1:0] src2,
  input logic [VEC_W-1:0] lane_opa,
  input logic [VEC_W-1:0] lane_opb,
  input logic [1:0]       round_mode,
  input logic             out_valid,
  input logic [VEC_W-1:0] dest_new
);
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_bcast_top_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_class == 2'd3 && bcast && src2_is_mem) |-> lane_opb[VEC_W-1 -: 32] == src2[31:0]);
  assert_no_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_class != 2'd3) |-> lane_opb == src2);

  assert_short_rounding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_class != 2'd3) |-> round_mode == global_rc);

  assert_legacy_opa_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_class == 2'd0) |-> lane_opa == dest_old);
  assert_legacy_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_class == 2'd0) |=> dest_new[VEC_W-1:128] == $past(dest_old[VEC_W-1:128]));

  assert_short_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_class == 2'd1) |=> dest_new[VEC_W-1:128] == '0);

  assert_zeroing_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_class == 2'd3 && use_mask && zero_mask && !opmask[0]) |=> dest_new[31:0] == 32'd0);
endmodule

bind lane_writeback_unit lwb_checker u_chk (.*);

// File: tb/lane_writeback_unit_test.sv
`timescale 1ns/1ps
module lane_writeback_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 512;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    enc_class, vlen_code;
  logic          bcast, src2_is_mem, use_mask, zero_mask;
  logic [15:0]   opmask;
  logic [1:0]    embed_rc, global_rc;
  logic [VW-1:0] dest_old, src1, src2, lane_res;
  logic [VW-1:0] lane_opa, lane_opb, dest_new;
  logic [1:0]    round_mode;
  logic          out_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  lane_writeback_unit uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [1:0] ec, input logic [1:0] vl);
    if (ec == 2'd0 || ec == 2'd1) return 4;
    if (ec == 2'd2) return 8;
    if (vl == 2'd0) return 4;
    if (vl == 2'd1) return 8;
    return 16;
  endfunction

  function automatic logic [VW-1:0] exp_dest(input logic [1:0] ec, input logic [1:0] vl,
      input logic um, input logic zm, input logic [15:0] om,
      input logic [VW-1:0] old_v, input logic [VW-1:0] res);
    logic [VW-1:0] r;
    int n;
    n = lanes_of(ec, vl);
    for (int j = 0; j < 16; j++) begin
      if (j >= n) r[j*32 +: 32] = (ec == 2'd0) ? old_v[j*32 +: 32] : 32'd0;
      else if (ec != 2'd3 || !um || om[j]) r[j*32 +: 32] = res[j*32 +: 32];
      else r[j*32 +: 32] = zm ? 32'd0 : old_v[j*32 +: 32];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_one(input logic [1:0] ec, input logic [1:0] vl, input logic bc, input logic mem,
      input logic um, input logic zm, input logic [15:0] om, input logic [1:0] erc, input logic [1:0] grc,
      input logic [VW-1:0] dold, input logic [VW-1:0] s1, input logic [VW-1:0] s2,
      input logic [VW-1:0] res, input string tag);
    logic [VW-1:0] e_opb, e_opa, e_dst;
    logic [1:0] e_rm;
    @(negedge clk);
    in_valid = 1'b1; enc_class = ec; vlen_code = vl; bcast = bc; src2_is_mem = mem;
    use_mask = um; zero_mask = zm; opmask = om; embed_rc = erc; global_rc = grc;
    dest_old = dold; src1 = s1; src2 = s2; lane_res = res;
    #1;
    for (int j = 0; j < 16; j++)
      e_opb[j*32 +: 32] = (ec == 2'd3 && bc && mem) ? s2[31:0] : s2[j*32 +: 32];
    e_opa = (ec == 2'd0) ? dold : s1;
    e_rm  = (ec == 2'd3 && vl == 2'd2 && bc && !mem) ? erc : grc;
    e_dst = exp_dest(ec, vl, um, zm, om, dold, res);
    chk(lane_opb == e_opb, {"R5 opb ", tag}, lane_opb, e_opb);
    chk(lane_opa == e_opa, {"R8 opa ", tag}, lane_opa, e_opa);
    chk(round_mode == e_rm, {"R6 round ", tag}, VW'(round_mode), VW'(e_rm));
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {"R11 valid ", tag}, VW'(out_valid), VW'(1));
    chk(dest_new == e_dst, {"R1 R2 R3 R4 R7 R9 R10 dest ", tag}, dest_new, e_dst);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] ones;
    logic [VW-1:0] a, b, c, d;
    void'($urandom(32'd20240611));
    ones = '1;
    rst_n = 1'b0; in_valid = 1'b0; enc_class = '0; vlen_code = '0; bcast = 0; src2_is_mem = 0;
    use_mask = 0; zero_mask = 0; opmask = '0; embed_rc = '0; global_rc = '0;
    dest_old = '0; src1 = '0; src2 = '0; lane_res = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 reset valid", VW'(out_valid), VW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 idle valid", VW'(out_valid), VW'(0));

    a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
    // R8: legacy keeps upper bits, first operand from destination
    run_one(2'd0, 2'd2, 1, 1, 1, 1, 16'h0000, 2'd3, 2'd1, ones, a, b, c, "legacy");
    // R9 R7: short 128 ignores armed zeroing mask; upper cleared
    run_one(2'd1, 2'd2, 0, 0, 1, 1, 16'h0000, 2'd2, 2'd0, ones, a, b, c, "short128");
    // R1: short 256 writes eight lanes
    run_one(2'd2, 2'd0, 1, 1, 1, 1, 16'h0000, 2'd1, 2'd3, ones, a, b, c, "short256");
    // R3: merging at full length
    run_one(2'd3, 2'd2, 0, 0, 1, 0, 16'hA5A5, 2'd1, 2'd2, ones, a, b, c, "merge512");
    // R4 R10: zeroing at 4 lanes with high mask bits set
    run_one(2'd3, 2'd0, 0, 0, 1, 1, 16'hFFF0, 2'd1, 2'd2, ones, a, b, c, "zero128");
    // R10: mask bits above 8 lanes
    run_one(2'd3, 2'd1, 0, 0, 1, 0, 16'hFF00, 2'd1, 2'd2, ones, a, b, c, "merge256");
    // R2: masked class without writemask
    run_one(2'd3, 2'd3, 0, 0, 0, 1, 16'h0000, 2'd0, 2'd1, ones, a, b, c, "nomask");
    // R5: broadcast from memory, global rounding
    run_one(2'd3, 2'd2, 1, 1, 0, 0, 16'h0000, 2'd3, 2'd1, ones, a, b, c, "bcast_mem");
    // R6: embedded rounding at full length register form
    run_one(2'd3, 2'd2, 1, 0, 0, 0, 16'h0000, 2'd3, 2'd1, ones, a, b, c, "embed512");
    // R6: same form at 256 bits uses global code
    run_one(2'd3, 2'd1, 1, 0, 0, 0, 16'h0000, 2'd3, 2'd1, ones, a, b, c, "embed256");

    for (int it = 0; it < 400; it++) begin
      d = rnd_vec(); a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
      run_one(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              16'($urandom), 2'($urandom), 2'($urandom), d, a, b, c, "random");
      if (($urandom % 4) == 0) begin
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 gap valid", VW'(out_valid), VW'(0));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule